// File: doc/BRIEF.md
# Receive Statistics Counter Bank with Threshold Interrupts

This block keeps a bank of receive statistics counters for a network interface. There are two groups with one counter per traffic class in each group. A frame counter steps by one for each event pulse on its input. An octet counter adds the byte count of a completed frame when its completion strobe is high. The classes are IPv4 good, IPv4 header error, IPv4 no-payload, IPv4 fragment, IPv4 with the UDP checksum disabled, IPv6 good, IPv6 header error, IPv6 no-payload, UDP good, UDP error, TCP good, TCP error, ICMP good and ICMP error. The classes take indices 0 upward in that order.

Each counter has a pending-interrupt flag in a 32-bit read-only status word. The flag is raised when an update carries the counter across half of its range. It is raised again when an update carries the counter up to, or past, its all-ones value. The flag is cleared when software reads that counter with the lowest byte lane enabled. A global stop-rollover control makes every counter hold at all-ones instead of wrapping. The registered OR of all flags drives a single interrupt line.

Software reads through a simple one-cycle read port with byte strobes. Word address `k` returns frame counter `k`. Word address `16+k` returns octet counter `k`. Word address 31 returns the status word. Status bit `j` belongs to the counter at word address `j`.

Top module: `rxstat_bank`

## Requirements
- R1: After reset every counter, every status bit, `rd_data` and `irq` read as zero.
- R2: A frame counter adds one in each cycle where its `frm_evt` bit is high. An octet counter adds `oct_bytes` in each cycle where its `oct_done` bit is high. With no such input, a counter holds its value.
- R3: When an update takes a counter from below 2^(W-1) to a value at or above it, the counter's status bit is set. This also applies when the update jumps over the exact half-range value.
- R4: When an update takes a counter from below 2^W-1 to that value or beyond, the counter's status bit is set. A counter that already equals 2^W-1 raises no new event.
- R5: With `stop_roll` low, a counter that passes 2^W-1 wraps modulo 2^W and keeps the excess.
- R6: With `stop_roll` high, an update that would pass 2^W-1 leaves the counter at 2^W-1, and further updates leave it there.
- R7: Address map and status layout:
  - Frame counter k is at word address k.
  - Octet counter k is at word address 16+k.
  - The status word is at word address 31.
  - Status bit k is frame counter k, and bit 16+k is octet counter k.
  - Status bits 14, 15, 30 and 31 always read 0.
  - Every unmapped address reads 0.
- R8: A read of a counter address with `rd_be[0]` high clears that counter's status bit. A read without `rd_be[0]` does not clear it, and neither does a read of the status word.
- R9: If a threshold event and a clearing read hit the same counter in one cycle, the status bit ends up set.
- R10: `rd_data` is registered and shows, one cycle after `rd_en`, the addressed value as it stood before that cycle's update. Byte lane i of `rd_data` is zero unless `rd_be[i]` is high, and `rd_data` is zero after a cycle with no read.
- R11: `irq` is high in the cycle after any status bit is high, and low in the cycle after all status bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_roll | input | 1 | 1: counters saturate at all-ones; 0: counters wrap |
| frm_evt | input | NUM_CNT | Per-class frame event pulse, one count per cycle |
| oct_done | input | NUM_CNT | Per-class frame completion strobe for the octet counters |
| oct_bytes | input | LEN_W | Byte count added to each strobed octet counter |
| rd_en | input | 1 | Read request |
| rd_addr | input | 6 | Word address of the read |
| rd_be | input | 4 | Byte lane strobes of the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered OR of all status bits |

## Verification
Some properties are checked by assertions on every cycle:
- a counter with no increment holds its value;
- a saturated counter under stop-rollover stays at all-ones;
- any threshold event leaves its status bit set on the next edge, even against a clearing read;
- a clear without an event drops the bit;
- an idle read port returns zero.

Other behaviour can only be shown by the bench's sweeps against an arithmetic model:
- the exact counter values after wrapping and saturation;
- octet updates that jump over a threshold;
- the address map and the byte-lane masking;
- the rule that only a lane-0 read clears a flag.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

   localparam int DATA_W    = 32;
   localparam int ADDR_W    = 6;
   localparam int LANES     = DATA_W / 8;
   localparam int OCT_BASE  = 16;
   localparam int STAT_ADDR = 31;

   // Traffic class index, shared by both counter groups.
   typedef enum int {
      CLS_V4_OK      = 0,
      CLS_V4_HDR_ERR = 1,
      CLS_V4_NO_PAY  = 2,
      CLS_V4_FRAG    = 3,
      CLS_V4_NO_CSUM = 4,
      CLS_V6_OK      = 5,
      CLS_V6_HDR_ERR = 6,
      CLS_V6_NO_PAY  = 7,
      CLS_UDP_OK     = 8,
      CLS_UDP_ERR    = 9,
      CLS_TCP_OK     = 10,
      CLS_TCP_ERR    = 11,
      CLS_ICMP_OK    = 12,
      CLS_ICMP_ERR   = 13
   } cls_e;

   // Status bits that are backed by a counter for a bank of n classes.
   function automatic logic [DATA_W-1:0] live_mask(input int n);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int k = 0; k < n; k++) begin
         m[k]            = 1'b1;
         m[OCT_BASE + k] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/rxstat_ctr.sv
module rxstat_ctr #(
   parameter int W     = 32,
   parameter int INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_roll,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     cnt_q,
   output logic             hit_o
);

   localparam logic [W-1:0] MAX_V  = {W{1'b1}};
   localparam logic [W-1:0] HALF_V = {1'b1, {(W-1){1'b0}}};

   if (W < 2 || W > 32) begin : g_bad_w
      $error("rxstat_ctr: W must lie in 2..32");
   end
   if (INC_W < 1 || INC_W >= W) begin : g_bad_inc
      $error("rxstat_ctr: INC_W must lie in 1..W-1");
   end

   logic [W-1:0] cnt_d;
   logic         half_hit;
   logic         max_hit;

   if (INC_W == 1) begin : g_unit
      // Unit step: thresholds are hit only from the value just below.
      always_comb begin
         half_hit = inc[0] && (cnt_q == HALF_V - 1'b1);
         max_hit  = inc[0] && (cnt_q == MAX_V - 1'b1);
         if (!inc[0]) begin
            cnt_d = cnt_q;
         end else if (stop_roll && (cnt_q == MAX_V)) begin
            cnt_d = cnt_q;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end else begin : g_wide
      // Multi-unit step: the update may jump over a threshold.
      logic [W:0] sum;
      always_comb begin
         sum      = {1'b0, cnt_q} + (W+1)'(inc);
         half_hit = !cnt_q[W-1] && sum[W-1];
         max_hit  = (cnt_q != MAX_V) && (sum >= {1'b0, MAX_V});
         if (stop_roll && (sum >= {1'b0, MAX_V})) begin
            cnt_d = MAX_V;
         end else begin
            cnt_d = sum[W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign hit_o = half_hit | max_hit;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (inc == '0) |=> $stable(cnt_q)); // R2

   AST_SAT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_roll && (cnt_q == MAX_V)) |=> (cnt_q == MAX_V)); // R6

endmodule

// File: rtl/rxstat_flags.sv
module rxstat_flags
   import rxstat_pkg::*;
#(
   parameter int NUM_CNT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] hit,
   input  logic [DATA_W-1:0] clr,
   output logic [DATA_W-1:0] st_q
);

   localparam logic [DATA_W-1:0] LIVE = live_mask(NUM_CNT);

   // An event in the same cycle as a clear leaves the flag set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         st_q <= (hit | (st_q & ~clr)) & LIVE;
      end
   end

   AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & LIVE) != '0) |=> ((st_q & $past(hit & LIVE)) == $past(hit & LIVE))); // R9

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~hit) != '0) |=> ((st_q & $past(clr & ~hit)) == '0)); // R8

endmodule

// File: rtl/rxstat_rdport.sv
module rxstat_rdport
   import rxstat_pkg::*;
#(
   parameter int NUM_CNT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [LANES-1:0]  rd_be,
   input  logic [DATA_W-1:0] frm_words [NUM_CNT],
   input  logic [DATA_W-1:0] oct_words [NUM_CNT],
   input  logic [DATA_W-1:0] status,
   output logic [DATA_W-1:0] clr,
   output logic [DATA_W-1:0] rd_data_q
);

   localparam logic [DATA_W-1:0] LIVE = live_mask(NUM_CNT);

   logic [DATA_W-1:0] word;
   logic [DATA_W-1:0] masked;

   always_comb begin
      word = '0;
      if (rd_addr == ADDR_W'(STAT_ADDR)) begin
         word = status;
      end
      for (int k = 0; k < NUM_CNT; k++) begin
         if (rd_addr == ADDR_W'(k)) begin
            word = frm_words[k];
         end
         if (rd_addr == ADDR_W'(OCT_BASE + k)) begin
            word = oct_words[k];
         end
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign masked[8*l +: 8] = word[8*l +: 8] & {8{rd_be[l]}};
   end

   // Status bit j clears on a lane-0 read of word address j.
   always_comb begin
      for (int j = 0; j < DATA_W; j++) begin
         clr[j] = rd_en && rd_be[0] && LIVE[j] && (rd_addr == ADDR_W'(j));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_q <= '0;
      end else if (rd_en) begin
         rd_data_q <= masked;
      end else begin
         rd_data_q <= '0;
      end
   end

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rd_data_q == '0)); // R10

endmodule

// File: rtl/rxstat_bank.sv
module rxstat_bank
   import rxstat_pkg::*;
#(
   parameter int NUM_CNT = 14,
   parameter int FRM_W   = 32,
   parameter int OCT_W   = 32,
   parameter int LEN_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stop_roll,
   input  logic [NUM_CNT-1:0] frm_evt,
   input  logic [NUM_CNT-1:0] oct_done,
   input  logic [LEN_W-1:0]   oct_bytes,
   input  logic               rd_en,
   input  logic [5:0]         rd_addr,
   input  logic [3:0]         rd_be,
   output logic [31:0]        rd_data,
   output logic               irq
);

   if (NUM_CNT < 1 || NUM_CNT > OCT_BASE) begin : g_bad_n
      $error("rxstat_bank: NUM_CNT must lie in 1..16");
   end
   if (FRM_W < 2 || FRM_W > DATA_W || OCT_W < 2 || OCT_W > DATA_W) begin : g_bad_w
      $error("rxstat_bank: counter widths must lie in 2..32");
   end
   if (LEN_W < 1 || LEN_W >= OCT_W) begin : g_bad_len
      $error("rxstat_bank: LEN_W must lie in 1..OCT_W-1");
   end

   logic [DATA_W-1:0]  frm_words [NUM_CNT];
   logic [DATA_W-1:0]  oct_words [NUM_CNT];
   logic [NUM_CNT-1:0] frm_hit;
   logic [NUM_CNT-1:0] oct_hit;
   logic [DATA_W-1:0]  hit_vec;
   logic [DATA_W-1:0]  clr_vec;
   logic [DATA_W-1:0]  status;
   logic               irq_q;

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cls
      logic [FRM_W-1:0] f_cnt;
      logic [OCT_W-1:0] o_cnt;
      logic [LEN_W-1:0] o_inc;

      assign o_inc = oct_done[k] ? oct_bytes : '0;

      rxstat_ctr #(.W(FRM_W), .INC_W(1)) u_frm (
         .clk       (clk),
         .rst_n     (rst_n),
         .stop_roll (stop_roll),
         .inc       (frm_evt[k]),
         .cnt_q     (f_cnt),
         .hit_o     (frm_hit[k])
      );

      rxstat_ctr #(.W(OCT_W), .INC_W(LEN_W)) u_oct (
         .clk       (clk),
         .rst_n     (rst_n),
         .stop_roll (stop_roll),
         .inc       (o_inc),
         .cnt_q     (o_cnt),
         .hit_o     (oct_hit[k])
      );

      assign frm_words[k] = DATA_W'(f_cnt);
      assign oct_words[k] = DATA_W'(o_cnt);
   end

   always_comb begin
      hit_vec = '0;
      for (int k = 0; k < NUM_CNT; k++) begin
         hit_vec[k]            = frm_hit[k];
         hit_vec[OCT_BASE + k] = oct_hit[k];
      end
   end

   rxstat_flags #(.NUM_CNT(NUM_CNT)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit_vec),
      .clr   (clr_vec),
      .st_q  (status)
   );

   rxstat_rdport #(.NUM_CNT(NUM_CNT)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .rd_be     (rd_be),
      .frm_words (frm_words),
      .oct_words (oct_words),
      .status    (status),
      .clr       (clr_vec),
      .rd_data_q (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= |status;
      end
   end

   assign irq = irq_q;

endmodule

// File: tb/tb_rxstat_bank.sv
`timescale 1ns/1ps
module tb_rxstat_bank;

   localparam int N  = 14;
   localparam int FW = 8;
   localparam int OW = 10;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_roll = 1'b0;
   logic [N-1:0]  frm_evt = '0;
   logic [N-1:0]  oct_done = '0;
   logic [LW-1:0] oct_bytes = '0;
   logic          rd_en = 1'b0;
   logic [5:0]    rd_addr = '0;
   logic [3:0]    rd_be = '0;
   logic [31:0]   rd_data;
   logic          irq;

   always #5 clk = ~clk;

   rxstat_bank #(.NUM_CNT(N), .FRM_W(FW), .OCT_W(OW), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .stop_roll(stop_roll), .frm_evt(frm_evt),
      .oct_done(oct_done), .oct_bytes(oct_bytes), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_be(rd_be), .rd_data(rd_data), .irq(irq)
   );

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 0;
   int  fref [N];
   int  oref [N];
   bit [31:0] sref;

   function automatic int upd(input int old, input int inc, input int w,
                              input bit stp, output bit ev);
      int h, m, n;
      h  = 1 << (w - 1);
      m  = (1 << w) - 1;
      n  = old + inc;
      ev = (old < h && n >= h) || (old < m && n >= m);
      if (stp) return (n > m) ? m : n;
      return n % (1 << w);
   endfunction

   function automatic bit [31:0] model_word(input int a);
      if (a < N) return 32'(fref[a]);
      if (a >= 16 && a < 16 + N) return 32'(oref[a - 16]);
      if (a == 31) return sref;
      return 32'h0;
   endfunction

   task automatic check(input string tag, input string what,
                        input bit [31:0] act, input bit [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      frm_evt = '0; oct_done = '0; rd_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < N; k++) begin fref[k] = 0; oref[k] = 0; end
      sref = '0;
   endtask

   // One cycle: drive, advance the model, compare registered outputs.
   task automatic tick(input bit [N-1:0] fe, input bit [N-1:0] od, input int bytes,
                       input bit rd, input int addr, input bit [3:0] be,
                       input string tag);
      bit [31:0] exp_rd, w, ev_vec, clr;
      bit        exp_irq, ev;
      @(negedge clk);
      frm_evt = fe; oct_done = od; oct_bytes = LW'(bytes);
      rd_en = rd; rd_addr = 6'(addr); rd_be = be;
      w = model_word(addr);
      exp_rd = '0;
      if (rd) for (int l = 0; l < 4; l++) if (be[l]) exp_rd[8*l +: 8] = w[8*l +: 8];
      exp_irq = |sref;
      ev_vec = '0;
      for (int k = 0; k < N; k++) begin
         fref[k] = upd(fref[k], fe[k] ? 1 : 0, FW, stop_roll, ev);
         ev_vec[k] = ev;
         oref[k] = upd(oref[k], od[k] ? bytes : 0, OW, stop_roll, ev);
         ev_vec[16 + k] = ev;
      end
      clr = '0;
      if (rd && be[0] && ((addr < N) || (addr >= 16 && addr < 16 + N))) clr[addr] = 1'b1;
      sref = (sref & ~clr) | ev_vec;
      @(posedge clk);
      #1;
      check(tag, "rd_data", rd_data, exp_rd);
      check("R11", "irq", 32'(irq), 32'(exp_irq));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit [N-1:0] fe, od;
      do_reset();

      // R1 / R7: everything zero after reset, whole address space.
      check("R1", "rd_data at reset", rd_data, 32'h0);
      check("R1", "irq at reset", 32'(irq), 32'h0);
      for (int a = 0; a < 64; a++) tick('0, '0, 0, 1'b1, a, 4'hF, "R1");

      // R2: simple counting then read-back.
      for (int c = 0; c < 5; c++) tick({N{1'b1}}, {N{1'b1}}, 3 + c, 1'b0, 0, 4'h0, "R2");
      for (int a = 0; a < 32; a++) tick('0, '0, 0, 1'b1, a, 4'hF, "R2");

      // R3 / R5: staggered frame events, wrapping, reads on every cycle.
      for (int c = 0; c < 700; c++) begin
         for (int k = 0; k < N; k++) fe[k] = ((c % (k + 1)) == 0);
         tick(fe, '0, 0, 1'b1, c % 32, (c % 5 == 0) ? 4'hE : 4'hF, "R3");
      end
      for (int a = 0; a < 32; a++) tick('0, '0, 0, 1'b1, a, 4'hF, "R5");

      // R4 / R8: octet jumps over thresholds, some reads without lane 0.
      for (int c = 0; c < 500; c++) begin
         for (int k = 0; k < N; k++) od[k] = (((c + k) % 3) != 0);
         tick('0, od, (c * 37 + 11) % 256, (c % 2) == 0, 16 + (c % 16),
              (c % 4 == 0) ? 4'hE : 4'hF, "R4");
         if (c % 50 == 0) tick('0, '0, 0, 1'b1, 31, 4'hF, "R8");
      end

      // R6: saturation under stop-rollover.
      @(negedge clk); stop_roll = 1'b1;
      for (int c = 0; c < 4000; c++) begin
         for (int k = 0; k < N; k++) fe[k] = ((c % (k + 1)) == 0);
         tick(fe, {N{1'b1}}, 200, (c % 7) == 0, c % 32, 4'hF, "R6");
      end
      for (int a = 0; a < 32; a++) tick({N{1'b1}}, {N{1'b1}}, 255, 1'b1, a, 4'hF, "R6");
      @(negedge clk); stop_roll = 1'b0;

      // R9: event and clearing read in the same cycle.
      do_reset();
      for (int c = 0; c < 127; c++) tick(14'h1, '0, 0, 1'b0, 0, 4'h0, "R9");
      tick(14'h1, '0, 0, 1'b1, 0, 4'h1, "R9");
      tick('0, '0, 0, 1'b1, 31, 4'hF, "R9");
      check("R9", "status bit0 after collision", {31'h0, sref[0]}, 32'h1);

      // R8 / R10: lane-masked read keeps the flag, lane-0 read clears it.
      tick('0, '0, 0, 1'b1, 0, 4'hE, "R10");
      tick('0, '0, 0, 1'b1, 31, 4'hF, "R8");
      tick('0, '0, 0, 1'b1, 31, 4'hF, "R8");
      tick('0, '0, 0, 1'b1, 0, 4'h1, "R8");
      tick('0, '0, 0, 1'b1, 31, 4'hF, "R8");
      tick('0, '0, 0, 1'b0, 31, 4'hF, "R10");
      check("R8", "status after lane-0 read", sref, 32'h0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule